// File: doc/BRIEF.md
# Handshaked GCD Coprocessor

This block finds the greatest common divisor of two unsigned integers by repeated subtraction. It pulls one operand from each of two FIFO-style input ports and pushes the result into a FIFO-style output port. Every port pairs a request driven by the block with an "ok" driven by the neighbouring FIFO. A transfer happens on a rising clock edge where both are high.

Inside the block, a two-register datapath shares a single subtractor. A registered order bit feeds the subtractor either A and B or B and A. The subtractor's borrow and zero flags steer a four-state controller:

- `ST_IDLE` is the reset state. It always moves on to `ST_FETCH`.
- `ST_FETCH` requests each operand that has not yet been captured. It moves to `ST_LOOP` once both operands are held.
- `ST_LOOP` works on the flags each cycle:
  - zero flag set: go to `ST_EMIT`;
  - borrow set: flip the order bit and store nothing;
  - otherwise: write the difference into a register.
- `ST_EMIT` holds the result request until it is accepted, then returns to `ST_FETCH`.

Normally the difference replaces the larger register. When the smaller register is zero, the difference replaces the zero register instead. This makes the two registers equal, so the non-zero operand is returned after one write.

Top module: `gcd_copro`

## Requirements
- R1: While reset is held, `opa_req`, `opb_req` and `res_req` are all low. On the first clock edge after reset is released, the block enters `ST_FETCH`, and both operand requests are then high.
- R2: `opa_req` is high only while the block waits for operand A. After the edge on which `opa_req` and `opa_ok` are both high, `opa_req` is low.
- R3: `opb_req` is high only while the block waits for operand B. After the edge on which `opb_req` and `opb_ok` are both high, `opb_req` is low.
- R4: An operand is captured only on an edge where its request and ok are both high. An ok (with any data) presented while the request is low has no effect on the result.
- R5: For two non-zero operands, `res_data` equals their greatest common divisor. The register that receives a difference is never loaded on a cycle whose subtraction borrowed.
- R6: If one operand is zero, the result is the other operand. If both are zero, the result is zero.
- R7: While `res_req` is high and `res_ok` is low, `res_req` stays high on the next cycle and `res_data` does not change.
- R8: After the edge on which `res_req` and `res_ok` are both high, `res_req` is low and both operand requests are high.
- R9: `res_req` is never high in the same cycle as either operand request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opa_data | input | WIDTH | Operand A from its FIFO |
| opa_ok | input | 1 | Operand A FIFO has data |
| opa_req | output | 1 | Read request to operand A FIFO |
| opb_data | input | WIDTH | Operand B from its FIFO |
| opb_ok | input | 1 | Operand B FIFO has data |
| opb_req | output | 1 | Read request to operand B FIFO |
| res_data | output | WIDTH | Result to output FIFO |
| res_req | output | 1 | Write request to output FIFO |
| res_ok | input | 1 | Output FIFO can accept |

## Verification
Both operand captures can complete on the same clock edge. In that case the fetch phase must skip straight to the loop, rather than waiting one more cycle or capturing an operand twice. Pseudo-random stalls on both ok inputs, swept over every operand pair up to 31, make same-edge and staggered captures occur in many combinations. Each case is judged by the returned divisor and by each request dropping right after its own transfer. Once an operand has been taken, its ok stays high with wrong data, so a second capture would show up as a wrong result.

// File: rtl/gcd_copro_pkg.sv
package gcd_copro_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOOP  = 2'd2,
        ST_EMIT  = 2'd3
    } gcd_state_e;

    localparam int unsigned LANES = 2;  // lane 0 = register A, lane 1 = register B

endpackage

// File: rtl/gcd_copro_subtractor.sv
module gcd_copro_subtractor #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] minuend,
    input  logic [WIDTH-1:0] subtrahend,
    output logic [WIDTH-1:0] diff,
    output logic             borrow,
    output logic             is_zero
);

    logic [WIDTH:0] wide;

    assign wide    = {1'b0, minuend} - {1'b0, subtrahend};
    assign diff    = wide[WIDTH-1:0];
    assign borrow  = wide[WIDTH];
    assign is_zero = (diff == '0);

endmodule

// File: rtl/gcd_copro_datapath.sv
module gcd_copro_datapath
    import gcd_copro_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa_data,
    input  logic [WIDTH-1:0] opb_data,
    input  logic [LANES-1:0] ld,
    input  logic [LANES-1:0] fill,
    input  logic             swap,
    output logic             sub_borrow,
    output logic             sub_zero,
    output logic             sub_y_zero,
    output logic [WIDTH-1:0] reg_a
);

    logic [LANES-1:0][WIDTH-1:0] fifo_in;
    logic [LANES-1:0][WIDTH-1:0] reg_q;
    logic [WIDTH-1:0]            op_x;
    logic [WIDTH-1:0]            op_y;
    logic [WIDTH-1:0]            diff;

    assign fifo_in[0] = opa_data;
    assign fifo_in[1] = opb_data;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WIDTH-1:0] nxt;
        assign nxt = fill[i] ? fifo_in[i] : diff;

        always_ff @(posedge clk) begin
            if (!rst_n)     reg_q[i] <= '0;
            else if (ld[i]) reg_q[i] <= nxt;
        end

        // R5: a difference is only stored when the subtraction did not wrap
        a_r5_no_wrap_store: assert property (@(posedge clk) disable iff (!rst_n)
            (ld[i] && !fill[i]) |-> !sub_borrow);
    end

    assign op_x = swap ? reg_q[1] : reg_q[0];
    assign op_y = swap ? reg_q[0] : reg_q[1];

    gcd_copro_subtractor #(.WIDTH(WIDTH)) u_sub (
        .minuend   (op_x),
        .subtrahend(op_y),
        .diff      (diff),
        .borrow    (sub_borrow),
        .is_zero   (sub_zero)
    );

    assign sub_y_zero = (op_y == '0);
    assign reg_a      = reg_q[0];

endmodule

// File: rtl/gcd_copro_ctrl.sv
module gcd_copro_ctrl
    import gcd_copro_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opa_ok,
    input  logic             opb_ok,
    input  logic             res_ok,
    input  logic             sub_borrow,
    input  logic             sub_zero,
    input  logic             sub_y_zero,
    output logic             opa_req,
    output logic             opb_req,
    output logic             res_req,
    output logic [LANES-1:0] ld,
    output logic [LANES-1:0] fill,
    output logic             swap
);

    gcd_state_e state_q, state_d;
    logic       have_a_q, have_b_q, swap_q;
    logic       take_a, take_b;

    assign take_a = (state_q == ST_FETCH) && !have_a_q && opa_ok;
    assign take_b = (state_q == ST_FETCH) && !have_b_q && opb_ok;
    assign swap   = swap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_a_q <= 1'b0;
            have_b_q <= 1'b0;
            swap_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (take_a) have_a_q <= 1'b1;
                    if (take_b) have_b_q <= 1'b1;
                end
                ST_LOOP: begin
                    if (!sub_zero && sub_borrow) swap_q <= !swap_q;
                end
                ST_EMIT: begin
                    if (res_ok) begin
                        have_a_q <= 1'b0;
                        have_b_q <= 1'b0;
                        swap_q   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_FETCH;
            ST_FETCH: if ((have_a_q || take_a) && (have_b_q || take_b)) state_d = ST_LOOP;
            ST_LOOP:  if (sub_zero) state_d = ST_EMIT;
            ST_EMIT:  if (res_ok) state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        opa_req = 1'b0;
        opb_req = 1'b0;
        res_req = 1'b0;
        ld      = '0;
        fill    = '0;
        unique case (state_q)
            ST_FETCH: begin
                opa_req = !have_a_q;
                opb_req = !have_b_q;
                fill    = '1;
                ld[0]   = take_a;
                ld[1]   = take_b;
            end
            ST_LOOP: begin
                if (!sub_zero && !sub_borrow) begin
                    // zero subtrahend: copy into it; otherwise shrink the minuend
                    if (sub_y_zero ^ swap_q) ld[1] = 1'b1;
                    else                     ld[0] = 1'b1;
                end
            end
            ST_EMIT:  res_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/gcd_copro.sv
module gcd_copro
    import gcd_copro_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa_data,
    input  logic             opa_ok,
    output logic             opa_req,
    input  logic [WIDTH-1:0] opb_data,
    input  logic             opb_ok,
    output logic             opb_req,
    output logic [WIDTH-1:0] res_data,
    output logic             res_req,
    input  logic             res_ok
);

    logic [LANES-1:0] ld, fill;
    logic             swap, sub_borrow, sub_zero, sub_y_zero;

    gcd_copro_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opa_ok    (opa_ok),
        .opb_ok    (opb_ok),
        .res_ok    (res_ok),
        .sub_borrow(sub_borrow),
        .sub_zero  (sub_zero),
        .sub_y_zero(sub_y_zero),
        .opa_req   (opa_req),
        .opb_req   (opb_req),
        .res_req   (res_req),
        .ld        (ld),
        .fill      (fill),
        .swap      (swap)
    );

    gcd_copro_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .opa_data  (opa_data),
        .opb_data  (opb_data),
        .ld        (ld),
        .fill      (fill),
        .swap      (swap),
        .sub_borrow(sub_borrow),
        .sub_zero  (sub_zero),
        .sub_y_zero(sub_y_zero),
        .reg_a     (res_data)
    );

    // R1: the first cycle out of reset shows every request low
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!opa_req && !opb_req && !res_req));

    // R2: operand A request drops right after its transfer
    a_r2_a_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_req && opa_ok) |=> !opa_req);

    // R3: operand B request drops right after its transfer
    a_r3_b_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (opb_req && opb_ok) |=> !opb_req);

    // R7: a stalled result holds its request and data
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_req && !res_ok) |=> (res_req && $stable(res_data)));

    // R8: an accepted result is followed by a fresh operand fetch
    a_r8_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (res_req && res_ok) |=> (!res_req && opa_req && opb_req));

    // R9: output and input requests never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_req && (opa_req || opb_req)));

endmodule

// File: tb/gcd_copro_tb_top.sv
`timescale 1ns/1ps
module gcd_copro_tb_top;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa_data = '0, opb_data = '0;
    logic         opa_ok = 1'b0, opb_ok = 1'b0, res_ok = 1'b0;
    logic         opa_req, opb_req, res_req;
    logic [W-1:0] res_data;

    int    n_checks = 0;
    int    n_err    = 0;
    int    cycles   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    gcd_copro #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .opa_data(opa_data), .opa_ok(opa_ok), .opa_req(opa_req),
        .opb_data(opb_data), .opb_ok(opb_ok), .opb_req(opb_req),
        .res_data(res_data), .res_req(res_req), .res_ok(res_ok)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic roll(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    function automatic int gcd_ref(input int a, input int b);
        int x, y, t;
        x = a; y = b;
        while (y != 0) begin
            t = x % y; x = y; y = t;
        end
        return x;
    endfunction

    task automatic run_pair(input int a, input int b);
        logic pa, pb, done, held, r0, r1, r2, r3, r4;
        logic [W-1:0] last;
        int guard, expv;
        string tag;
        pa = 1'b1; pb = 1'b1; done = 1'b0; held = 1'b0; guard = 0; last = '0;
        expv = gcd_ref(a, b);
        tag = (a == 0 || b == 0) ? "R6 zero operand" : "R5 gcd value";
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
            roll(r0); roll(r1); roll(r2); roll(r3); roll(r4);
            // R4: once taken, ok stays high with wrong data; it must be ignored
            if (pa) begin opa_data = W'(a); opa_ok = r0 | r1; end
            else    begin opa_data = ~W'(a); opa_ok = 1'b1; end
            if (pb) begin opb_data = W'(b); opb_ok = r2 | r3; end
            else    begin opb_data = ~W'(b) ^ W'(8'h5A); opb_ok = 1'b1; end
            res_ok = r4 | r1;
            check(!(opa_req && !pa), "R2 request after capture", int'(opa_req), 0);
            check(!(opb_req && !pb), "R3 request after capture", int'(opb_req), 0);
            check(!(res_req && (opa_req || opb_req)), "R9 overlap", int'(res_req), 0);
            if (res_req) begin
                if (held) check(res_data == last, "R7 data stable", int'(res_data), int'(last));
                held = 1'b1;
                last = res_data;
                if (res_ok) begin
                    check(int'(res_data) == expv, tag, int'(res_data), expv);
                    done = 1'b1;
                end
            end
            if (opa_req && opa_ok && pa) pa = 1'b0;
            if (opb_req && opb_ok && pb) pb = 1'b0;
        end
        if (!done) check(1'b0, "R5 pair timeout", guard, 4000);
        @(negedge clk);
        opa_ok = 1'b0; opb_ok = 1'b0; res_ok = 1'b0;
        check(!res_req && opa_req && opb_req, "R8 refetch after accept",
              int'({res_req, opa_req, opb_req}), 3);
    endtask

    initial begin
        rst_n = 1'b0;
        opa_ok = 1'b1; opb_ok = 1'b1; res_ok = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!opa_req && !opb_req && !res_req, "R1 quiet in reset",
                  int'({opa_req, opb_req, res_req}), 0);
        end
        opa_ok = 1'b0; opb_ok = 1'b0; res_ok = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(opa_req && opb_req && !res_req, "R1 fetch after reset",
              int'({opa_req, opb_req, res_req}), 6);

        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++)
                run_pair(a, b);

        run_pair(255, 1);
        run_pair(1, 255);
        run_pair(255, 255);
        run_pair(240, 180);
        run_pair(0, 200);
        run_pair(200, 0);
        run_pair(128, 96);
        run_pair(233, 144);

        summary();
        $finish;
    end

endmodule